// File: doc/BRIEF.md
# Cache Line Refill Timing Controller

This block answers a single cache miss by fetching a four-word line from a small DRAM model that sits behind a one-word-wide memory bus. It reproduces the bus timing of that refill cycle by cycle. The cache raises a miss request with a line (block) address and keeps it high. The controller then returns the four 32-bit words over a valid/ready channel, marks the last word with a done flag, and reports how many bus cycles the whole refill took.

A static organisation input selects how the DRAM is built. In split-row mode every word lives in a different row, so each word pays the full row access. In open-row mode the whole line sits in one row: the first word pays the row access and each further word pays only a column access. In banked mode four banks, chosen by the low two bits of the word address, are read in parallel and their words leave on consecutive cycles. Cycle numbering below counts cycle 1 as the first clock cycle after the edge that accepts the request. Cycle 1 is the address cycle, a row access takes 15 cycles and a column access takes 5.

Top module: `line_refill_ctrl`

## Requirements
- R1: After reset the controller is idle: `word_valid` and `refill_done` are low and `penalty_cyc` reads 0.
- R2: A request is accepted only while the controller is idle. The line address and organisation are captured at acceptance, and later changes to `miss_blk` or `org_mode` during that refill have no effect on the returned data or timing.
- R3: With `org_mode` = 0 (split rows) and no backpressure, word k (k = 0..3) is presented in cycle 17 + 15·k, so the last word is in cycle 62 and the penalty is 62.
- R4: With `org_mode` = 1 (open row) and no backpressure, word k is presented in cycle 17 + 5·k, so the last word is in cycle 32 and the penalty is 32.
- R5: With `org_mode` = 2 (banked) and no backpressure, the words are presented in cycles 17, 18, 19 and 20, and the penalty is 20.
- R6: `org_mode` = 3 produces the same timing as `org_mode` = 0.
- R7: Words come out in ascending offset order, with `word_ofs` = k. The word at word address a = 4·blk + k holds {8'hD7, a[7:0], ~a[7:0], (3·a)[7:0]}.
- R8: `refill_done` is high exactly while the last word (offset 3) is on the channel, and low for the other words.
- R9: While `word_valid` is high and `word_ready` is low, the word, its offset and `refill_done` stay unchanged. During that time the whole fetch schedule is frozen, so every later word is delayed by the number of stall cycles.
- R10: The cycle from acceptance up to the transfer of the last word is counted, including stall cycles. That count appears on `penalty_cyc` from the following cycle and holds until the next refill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory bus clock |
| rst | input | 1 | Synchronous active-high reset |
| org_mode | input | 2 | DRAM organisation: 0 split rows, 1 open row, 2 banked, 3 as 0 |
| miss_req | input | 1 | Miss request, held high until the last word transfers |
| miss_blk | input | BLK_AW (4) | Line address of the miss |
| word_valid | output | 1 | A refill word is on `word_data` |
| word_ready | input | 1 | The cache takes the word this cycle |
| word_data | output | 32 | Refill word |
| word_ofs | output | 2 | Offset of the word within the line |
| refill_done | output | 1 | High while the last word is presented |
| penalty_cyc | output | PEN_W (16) | Cycle count of the last completed refill |

## Verification
The bench times every word against the acceptance edge in each of the four mode codes. A controller that overlaps the wrong part of the schedule would show up as words one step early or late, or as a penalty of 61 or 63 instead of 62, 32 or 20. Backpressure is applied on a middle word and on the final word. A design that lets the fetch countdown keep running while the channel is stalled would send later words too soon and report a penalty smaller than nominal plus stall. Mode and address are changed in the middle of a refill, and a controller that failed to capture them at acceptance would return words from the wrong line or with banked timing. Back-to-back refills check that the held request is not accepted twice, and that the penalty of the previous refill is not lost.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ORG_SPLIT_ROW = 2'd0,
    ORG_OPEN_ROW  = 2'd1,
    ORG_BANKED    = 2'd2,
    ORG_SPARE     = 2'd3
  } org_e;

  // Contents of the DRAM model at word address a.
  function automatic logic [31:0] fill_word(input logic [15:0] a);
    logic [15:0] tri_a;
    tri_a = a * 16'd3;
    return {8'hD7, a[7:0], ~a[7:0], tri_a[7:0]};
  endfunction

endpackage

// File: rtl/refill_sched.sv
module refill_sched #(
  parameter int ADDR_CYC = 1,
  parameter int ROW_CYC  = 15,
  parameter int COL_CYC  = 5,
  parameter int WPB      = 4,
  parameter int CNT_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  refill_pkg::org_e       org_in,
  input  logic                   hold,
  output logic                   issue,
  output logic                   last_issue,
  output logic [$clog2(WPB)-1:0] issue_idx,
  output logic                   busy
);
  import refill_pkg::*;

  localparam int IDX_W = $clog2(WPB);
  localparam logic [CNT_W-1:0] FIRST_WAIT = CNT_W'(ADDR_CYC + ROW_CYC);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(WPB - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  org_e             org_q;
  logic [CNT_W-1:0] step;

  always_comb begin
    case (org_q)
      ORG_OPEN_ROW: step = CNT_W'(COL_CYC);
      ORG_BANKED:   step = CNT_W'(1);
      default:      step = CNT_W'(ROW_CYC);
    endcase
  end

  assign issue      = busy_q && !hold && (cnt_q == CNT_W'(1));
  assign last_issue = issue && (idx_q == LAST_IDX);
  assign issue_idx  = idx_q;
  assign busy       = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      org_q  <= ORG_SPLIT_ROW;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= FIRST_WAIT;
      idx_q  <= '0;
      org_q  <= org_in;
    end else if (busy_q && !hold) begin
      if (cnt_q == CNT_W'(1)) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          cnt_q <= step;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R9
  sched_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && hold && !start) |=> ($stable(cnt_q) && $stable(idx_q)));

  // R3
  sched_wait_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q != '0));

endmodule

// File: rtl/refill_banks.sv
module refill_banks #(
  parameter int NBANK   = 4,
  parameter int BANK_AW = 4,
  parameter int DW      = 32
) (
  input  logic                               clk,
  input  logic                               rd_en,
  input  logic [BANK_AW+$clog2(NBANK)-1:0]   rd_addr,
  output logic [DW-1:0]                      rd_data
);
  localparam int SEL_W      = $clog2(NBANK);
  localparam int BANK_DEPTH = 1 << BANK_AW;

  logic [DW-1:0]    bank_q [NBANK];
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_in;
  logic [BANK_AW-1:0] row_in;

  assign sel_in = rd_addr[SEL_W-1:0];
  assign row_in = rd_addr[BANK_AW+SEL_W-1:SEL_W];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [BANK_DEPTH];

    initial begin
      for (int r = 0; r < BANK_DEPTH; r++) begin
        mem[r] = DW'(refill_pkg::fill_word(16'(r * NBANK + b)));
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en && (sel_in == SEL_W'(b))) begin
        bank_q[b] <= mem[row_in];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      sel_q <= sel_in;
    end
  end

  assign rd_data = bank_q[sel_q];

endmodule

// File: rtl/refill_ret.sv
module refill_ret #(
  parameter int WPB     = 4,
  parameter int PEN_W   = 16,
  parameter int MIN_PEN = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   issue,
  input  logic                   last_issue,
  input  logic [$clog2(WPB)-1:0] issue_idx,
  input  logic                   word_ready,
  output logic                   word_valid,
  output logic [$clog2(WPB)-1:0] word_ofs,
  output logic                   done,
  output logic                   hold,
  output logic [PEN_W-1:0]       penalty
);
  localparam int IDX_W = $clog2(WPB);

  logic             valid_q;
  logic [IDX_W-1:0] ofs_q;
  logic             done_q;
  logic             run_q;
  logic [PEN_W-1:0] cnt_q;
  logic [PEN_W-1:0] pen_q;
  logic             xfer;
  logic             final_xfer;

  assign xfer       = valid_q && word_ready;
  assign final_xfer = xfer && done_q;
  assign hold       = valid_q && !word_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ofs_q   <= '0;
      done_q  <= 1'b0;
    end else if (issue) begin
      valid_q <= 1'b1;
      ofs_q   <= issue_idx;
      done_q  <= last_issue;
    end else if (xfer) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      pen_q <= '0;
    end else begin
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= PEN_W'(1);
      end else if (final_xfer) begin
        run_q <= 1'b0;
        pen_q <= cnt_q;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_valid = valid_q;
  assign word_ofs   = ofs_q;
  assign done       = done_q;
  assign penalty    = pen_q;

  // R9
  ret_stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !word_ready) |=> (valid_q && $stable(ofs_q) && $stable(done_q)));

  // R8
  ret_done_valid_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> valid_q);

  // R10
  ret_pen_floor_chk: assert property (@(posedge clk) disable iff (rst)
    final_xfer |=> (pen_q >= PEN_W'(MIN_PEN)));

  // R8
  ret_done_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (ofs_q == IDX_W'(WPB - 1)));

endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl #(
  parameter int BLK_AW   = 4,
  parameter int DW       = 32,
  parameter int PEN_W    = 16,
  parameter int ADDR_CYC = 1,
  parameter int ROW_CYC  = 15,
  parameter int COL_CYC  = 5,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        org_mode,
  input  logic              miss_req,
  input  logic [BLK_AW-1:0] miss_blk,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [DW-1:0]     word_data,
  output logic [1:0]        word_ofs,
  output logic              refill_done,
  output logic [PEN_W-1:0]  penalty_cyc
);
  import refill_pkg::*;

  localparam int WPB     = 4;
  localparam int IDX_W   = $clog2(WPB);
  localparam int WADDR_W = BLK_AW + IDX_W;
  localparam int MIN_PEN = ADDR_CYC + ROW_CYC + WPB;

  logic              sched_busy;
  logic              issue;
  logic              last_issue;
  logic [IDX_W-1:0]  issue_idx;
  logic              hold;
  logic              start;
  logic              busy;
  logic [BLK_AW-1:0] blk_q;
  logic [IDX_W-1:0]  ofs_int;

  assign busy  = sched_busy || word_valid;
  assign start = miss_req && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= '0;
    end else if (start) begin
      blk_q <= miss_blk;
    end
  end

  refill_sched #(
    .ADDR_CYC(ADDR_CYC), .ROW_CYC(ROW_CYC), .COL_CYC(COL_CYC),
    .WPB(WPB), .CNT_W(CNT_W)
  ) sched_i (
    .clk(clk), .rst(rst), .start(start), .org_in(org_e'(org_mode)),
    .hold(hold), .issue(issue), .last_issue(last_issue),
    .issue_idx(issue_idx), .busy(sched_busy)
  );

  refill_banks #(.NBANK(WPB), .BANK_AW(BLK_AW), .DW(DW)) banks_i (
    .clk(clk), .rd_en(issue), .rd_addr(WADDR_W'({blk_q, issue_idx})),
    .rd_data(word_data)
  );

  refill_ret #(.WPB(WPB), .PEN_W(PEN_W), .MIN_PEN(MIN_PEN)) ret_i (
    .clk(clk), .rst(rst), .start(start), .issue(issue),
    .last_issue(last_issue), .issue_idx(issue_idx), .word_ready(word_ready),
    .word_valid(word_valid), .word_ofs(ofs_int), .done(refill_done),
    .hold(hold), .penalty(penalty_cyc)
  );

  assign word_ofs = 2'(ofs_int);

  // R2
  top_accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sched_busy) |-> $past(miss_req));

  // R9
  top_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |=> $stable(word_data));

  // R2
  top_blk_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> $stable(blk_q));

endmodule

// File: tb/line_refill_ctrl_tb_top.sv
module line_refill_ctrl_tb_top;
  localparam int PEN_W = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  org_mode;
  logic        miss_req;
  logic [3:0]  miss_blk;
  logic        word_valid;
  logic        word_ready;
  logic [31:0] word_data;
  logic [1:0]  word_ofs;
  logic        refill_done;
  logic [PEN_W-1:0] penalty_cyc;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  line_refill_ctrl dut_i (
    .clk(clk), .rst(rst), .org_mode(org_mode), .miss_req(miss_req),
    .miss_blk(miss_blk), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .word_ofs(word_ofs), .refill_done(refill_done),
    .penalty_cyc(penalty_cyc)
  );

  function automatic logic [31:0] exp_word(input int a);
    logic [7:0] lo;
    logic [7:0] t3;
    lo = 8'(a);
    t3 = 8'(a * 3);
    return {8'hD7, lo, ~lo, t3};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; miss_req = 1'b0; org_mode = 2'd0; miss_blk = '0; word_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(word_valid == 1'b0, "R1 valid", word_valid, 0);
    chk(refill_done == 1'b0, "R1 done", refill_done, 0);
    chk(penalty_cyc == '0, "R1 penalty", penalty_cyc, 0);
  endtask

  // One refill; stall_k < 0 means no backpressure. poke changes inputs mid-refill.
  task automatic t_refill(input logic [1:0] mode, input logic [3:0] blk,
                          input int stall_k, input int stall_len, input bit poke,
                          input string req);
    int step;
    int t;
    int k;
    int stalled;
    int expt;
    int extra;
    bit seen;
    bit fin;
    step  = (mode == 2'd1) ? 5 : ((mode == 2'd2) ? 1 : 15);
    extra = (stall_k >= 0) ? stall_len : 0;
    @(negedge clk);
    org_mode = mode; miss_blk = blk; miss_req = 1'b1; word_ready = 1'b1;
    @(posedge clk);
    t = 0; k = 0; stalled = 0; seen = 1'b0; fin = 1'b0;
    while (!fin && t < 400) begin
      @(negedge clk);
      t++;
      word_ready = 1'b1;
      if (poke && t == 5) begin
        miss_blk = ~blk;
        org_mode = 2'd2;
      end
      if (word_valid) begin
        if (!seen) begin
          expt = 17 + step * k + ((stall_k >= 0 && k > stall_k) ? stall_len : 0);
          chk(t == expt, {req, " R7 word time"}, t, expt);
          chk(word_data == exp_word(int'(blk) * 4 + k), {req, " R7 data"},
              word_data, exp_word(int'(blk) * 4 + k));
          chk(word_ofs == 2'(k), {req, " R7 offset"}, word_ofs, k);
          chk(refill_done == (k == 3), {req, " R8 done flag"}, refill_done, (k == 3));
          seen = 1'b1;
        end
        if (k == stall_k && stalled < stall_len) begin
          word_ready = 1'b0;
          stalled++;
          if (stalled > 1) begin
            chk(word_data == exp_word(int'(blk) * 4 + k), {req, " R9 held data"},
                word_data, exp_word(int'(blk) * 4 + k));
          end
        end
        if (word_ready) begin
          if (k == 3) begin
            fin = 1'b1;
            miss_req = 1'b0;
          end
          k++;
          seen = 1'b0;
        end
      end
    end
    chk(fin, {req, " completion"}, fin, 1);
    @(negedge clk);
    chk(word_valid == 1'b0, {req, " R2 no reaccept"}, word_valid, 0);
    chk(int'(penalty_cyc) == 16 + 3 * step + 1 + extra, {req, " R10 penalty"},
        penalty_cyc, 16 + 3 * step + 1 + extra);
  endtask

  task automatic t_pen_hold();
    int p;
    p = int'(penalty_cyc);
    repeat (10) @(negedge clk);
    chk(int'(penalty_cyc) == p, "R10 penalty hold", penalty_cyc, p);
  endtask

  initial begin
    t_reset();
    t_refill(2'd0, 4'd3,  -1, 0, 1'b0, "R3 split");
    t_pen_hold();
    t_refill(2'd1, 4'd7,  -1, 0, 1'b0, "R4 open");
    t_refill(2'd2, 4'd12, -1, 0, 1'b0, "R5 banked");
    t_refill(2'd3, 4'd1,  -1, 0, 1'b0, "R6 spare");
    t_refill(2'd0, 4'd9,  -1, 0, 1'b1, "R2 split poke");
    t_refill(2'd1, 4'd5,  -1, 0, 1'b1, "R2 open poke");
    t_refill(2'd2, 4'd14,  1, 3, 1'b0, "R9 banked stall");
    t_refill(2'd1, 4'd0,   3, 2, 1'b0, "R9 open last stall");
    t_refill(2'd0, 4'd15,  0, 4, 1'b0, "R9 split stall");
    t_refill(2'd2, 4'd2,  -1, 0, 1'b0, "R5 banked again");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule